// File: doc/BRIEF.md
# DMA Page Exclusion Checker

This block sits on the upstream path from I/O devices to system memory. It checks every DMA request before the request goes further. A request carries a device identifier, a byte address, a length and a read/write direction. The block resolves the device identifier to a protection domain through a small map table.

Each domain has its own exclusion bitmap in physical memory, with one bit for every 4 KB page. The block reads the bytes of that bitmap that cover the pages the request touches. It then returns one decision: allow or block. Memory-mapped I/O addresses are checked in exactly the same way as DRAM addresses.

Software programs three things through a write-only configuration port: the map table, the bitmap base address of each domain, and a global enable. The block handles one request at a time. The bitmap read port uses request/response handshakes and may answer after any latency. The first blocked request is latched into a sticky fault record, which stays visible on dedicated outputs until software clears it.

Top module: `dma_page_guard`

## Requirements
- R1: The block accepts a new request (`req_ready`=1) only when no request is in flight. A decision stays on `dec_*` without change until `dec_ready` is high at a clock edge.
- R2: The domain is taken from the lowest-index map entry that is valid and whose device field equals `req_dev`. Domains run from 0 to DOM_N-1.
- R3: When enabled, a request whose device matches no valid map entry is blocked (`dec_allow`=0) and issues no bitmap read.
- R4: For page number p = addr[31:12], the bitmap byte is read at domain_base + p[19:3], and bit p[2:0] of that byte is tested. A value of 1 means the page is excluded and the request is blocked.
- R5: `req_len` holds the byte count minus one, so the last byte is at addr+req_len, wrapping modulo 2^32. If the first and last byte lie in different pages, the first page is read first. If the first page is excluded, the request is blocked after one read. Otherwise the last page is read as well, and the request is blocked if that page is excluded.
- R6: Every decision returns the request's `dev`, `addr`, `len` and `write` fields unchanged. `dec_allow`=1 means forward; `dec_allow`=0 is the error response to the device.
- R7: While the global enable is 0, every request is allowed with no bitmap read. The enable is sampled when the request is accepted.
- R8: The first blocked decision sets `stat_valid` and records its device ID and address. Later blocks leave the record unchanged. A control write with bit 1 set clears the record; a block in the same cycle is recorded.
- R9: `rd_req_addr` holds steady while `rd_req_valid` is high and `rd_req_ready` is low. Exactly one one-byte response is consumed for each accepted read.
- R10: Configuration writes use `cfg_addr[5:4]` to select the target. 0 is control: bit 0 is enable, bit 1 clears status. 1 is map entry `cfg_addr[3:0]`: bit 31 is valid, bits [16+:DOM_W] are the domain, bits [15:0] are the device. 2 is the base of domain `cfg_addr[3:0]`. Indexes out of range are ignored.
- R11: After reset the map is empty, enable is 1, `stat_valid` is 0, `req_ready` is 1, and no decision or read is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration target select and index |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_dev | input | DEV_W | Requesting device identifier |
| req_addr | input | AW | Request byte address |
| req_len | input | LEN_W | Byte count minus one |
| req_write | input | 1 | Direction, 1 = write |
| dec_valid | output | 1 | Decision present |
| dec_ready | input | 1 | Decision taken |
| dec_allow | output | 1 | 1 = forward, 0 = error response |
| dec_dev | output | DEV_W | Device identifier of the decided request |
| dec_addr | output | AW | Address of the decided request |
| dec_len | output | LEN_W | Length field of the decided request |
| dec_write | output | 1 | Direction of the decided request |
| rd_req_valid | output | 1 | Bitmap byte read request |
| rd_req_ready | input | 1 | Bitmap read request taken |
| rd_req_addr | output | AW | Bitmap byte address |
| rd_rsp_valid | input | 1 | Bitmap read data present |
| rd_rsp_data | input | 8 | Bitmap byte |
| stat_valid | output | 1 | Sticky fault record present |
| stat_dev | output | DEV_W | Device of the recorded fault |
| stat_addr | output | AW | Address of the recorded fault |

## Verification
The hardest case to reach is a request that straddles a page boundary where the first page is clear and the second is excluded. Only the second bitmap read can block it, and that read may take several cycles to return. The stimulus places excluded bits for neighbouring pages inside a single bitmap byte and sends requests that straddle the boundary in both orders. The memory responder varies its request acceptance and response latency from one cycle to the next. The decision channel is backpressured as well, so each decision has to wait.

// File: rtl/dma_page_guard.sv
module dma_page_guard #(
  parameter int DEV_W = 16,
  parameter int AW    = 32,
  parameter int LEN_W = 12,
  parameter int MAP_N = 4,
  parameter int DOM_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [5:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [DEV_W-1:0] req_dev,
  input  logic [AW-1:0]    req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_write,
  output logic             dec_valid,
  input  logic             dec_ready,
  output logic             dec_allow,
  output logic [DEV_W-1:0] dec_dev,
  output logic [AW-1:0]    dec_addr,
  output logic [LEN_W-1:0] dec_len,
  output logic             dec_write,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [AW-1:0]    rd_req_addr,
  input  logic             rd_rsp_valid,
  input  logic [7:0]       rd_rsp_data,
  output logic             stat_valid,
  output logic [DEV_W-1:0] stat_dev,
  output logic [AW-1:0]    stat_addr
);
  localparam int PG_SH = 12;
  localparam int PG_W  = AW - PG_SH;
  localparam int DOM_W = (DOM_N > 1) ? $clog2(DOM_N) : 1;

  typedef enum logic [1:0] {S_IDLE, S_RDREQ, S_RDWAIT, S_DEC} st_t;
  st_t st;

  logic             en_q;
  logic             map_vld [MAP_N];
  logic [DEV_W-1:0] map_dev [MAP_N];
  logic [DOM_W-1:0] map_dom [MAP_N];
  logic [AW-1:0]    dom_base [DOM_N];

  logic [DEV_W-1:0] q_dev;
  logic [AW-1:0]    q_addr;
  logic [LEN_W-1:0] q_len;
  logic             q_wr;
  logic             q_allow;
  logic [AW-1:0]    q_base;
  logic [PG_W-1:0]  q_pg;
  logic [PG_W-1:0]  q_pg2;
  logic             q_second;

  logic             hit;
  logic [DOM_W-1:0] hit_dom;
  logic             map_ok;
  logic [AW-1:0]    hit_base;
  logic [AW-1:0]    end_addr;
  logic [PG_W-1:0]  pg_first;
  logic [PG_W-1:0]  pg_last;
  logic             stat_clr;
  logic             fault;
  logic             page_bit;

  always_comb begin
    hit = 1'b0;
    hit_dom = '0;
    for (int i = MAP_N - 1; i >= 0; i--) begin
      if (map_vld[i] && map_dev[i] == req_dev) begin
        hit = 1'b1;
        hit_dom = map_dom[i];
      end
    end
  end

  always_comb begin
    map_ok = 1'b0;
    hit_base = '0;
    for (int d = 0; d < DOM_N; d++) begin
      if (hit && hit_dom == DOM_W'(d)) begin
        map_ok = 1'b1;
        hit_base = dom_base[d];
      end
    end
  end

  assign end_addr = req_addr + AW'(req_len);
  assign pg_first = req_addr[AW-1:PG_SH];
  assign pg_last  = end_addr[AW-1:PG_SH];
  assign page_bit = rd_rsp_data[q_pg[2:0]];

  assign req_ready    = (st == S_IDLE);
  assign rd_req_valid = (st == S_RDREQ);
  assign rd_req_addr  = q_base + AW'(q_pg[PG_W-1:3]);
  assign dec_valid    = (st == S_DEC);
  assign dec_allow    = q_allow;
  assign dec_dev      = q_dev;
  assign dec_addr     = q_addr;
  assign dec_len      = q_len;
  assign dec_write    = q_wr;

  assign stat_clr = cfg_we && cfg_addr[5:4] == 2'd0 && cfg_wdata[1];
  assign fault    = dec_valid && dec_ready && !q_allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b1;
      for (int i = 0; i < MAP_N; i++) begin
        map_vld[i] <= 1'b0;
        map_dev[i] <= '0;
        map_dom[i] <= '0;
      end
      for (int d = 0; d < DOM_N; d++) dom_base[d] <= '0;
    end else if (cfg_we) begin
      case (cfg_addr[5:4])
        2'd0: en_q <= cfg_wdata[0];
        2'd1: for (int i = 0; i < MAP_N; i++) begin
          if (cfg_addr[3:0] == 4'(i)) begin
            map_vld[i] <= cfg_wdata[31];
            map_dev[i] <= cfg_wdata[DEV_W-1:0];
            map_dom[i] <= cfg_wdata[16 +: DOM_W];
          end
        end
        2'd2: for (int d = 0; d < DOM_N; d++) begin
          if (cfg_addr[3:0] == 4'(d)) dom_base[d] <= cfg_wdata[AW-1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      q_dev    <= '0;
      q_addr   <= '0;
      q_len    <= '0;
      q_wr     <= 1'b0;
      q_allow  <= 1'b0;
      q_base   <= '0;
      q_pg     <= '0;
      q_pg2    <= '0;
      q_second <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          q_dev    <= req_dev;
          q_addr   <= req_addr;
          q_len    <= req_len;
          q_wr     <= req_write;
          q_base   <= hit_base;
          q_pg     <= pg_first;
          q_pg2    <= pg_last;
          q_second <= (pg_last != pg_first);
          if (!en_q) begin
            q_allow <= 1'b1;
            st      <= S_DEC;
          end else if (!map_ok) begin
            q_allow <= 1'b0;
            st      <= S_DEC;
          end else begin
            st <= S_RDREQ;
          end
        end
        S_RDREQ: if (rd_req_ready) st <= S_RDWAIT;
        S_RDWAIT: if (rd_rsp_valid) begin
          if (page_bit) begin
            q_allow <= 1'b0;
            st      <= S_DEC;
          end else if (q_second) begin
            q_second <= 1'b0;
            q_pg     <= q_pg2;
            st       <= S_RDREQ;
          end else begin
            q_allow <= 1'b1;
            st      <= S_DEC;
          end
        end
        S_DEC: if (dec_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_valid <= 1'b0;
      stat_dev   <= '0;
      stat_addr  <= '0;
    end else begin
      if (stat_clr) stat_valid <= 1'b0;
      if (fault && (!stat_valid || stat_clr)) begin
        stat_valid <= 1'b1;
        stat_dev   <= q_dev;
        stat_addr  <= q_addr;
      end
    end
  end

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  // R1
  dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_ready |=> dec_valid && $stable({dec_allow, dec_dev, dec_addr, dec_len, dec_write}));

  // R1
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R7
  bypass_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !en_q |=> dec_valid && dec_allow);

  // R3
  unmapped_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && en_q && !map_ok |=> dec_valid && !dec_allow);

  // R8
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && !stat_clr |=> stat_valid && $stable(stat_dev) && $stable(stat_addr));
endmodule

// File: tb/dma_page_guard_tb.sv
module dma_page_guard_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_dev = '0;
  logic [31:0] req_addr = '0;
  logic [11:0] req_len = '0;
  logic        req_write = 1'b0;
  logic        dec_valid;
  logic        dec_ready = 1'b0;
  logic        dec_allow;
  logic [15:0] dec_dev;
  logic [31:0] dec_addr;
  logic [11:0] dec_len;
  logic        dec_write;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b0;
  logic [31:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [7:0]  rd_rsp_data = '0;
  logic        stat_valid;
  logic [15:0] stat_dev;
  logic [31:0] stat_addr;

  dma_page_guard u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_dev(req_dev),
    .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_allow(dec_allow),
    .dec_dev(dec_dev), .dec_addr(dec_addr), .dec_len(dec_len), .dec_write(dec_write),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .stat_valid(stat_valid), .stat_dev(stat_dev), .stat_addr(stat_addr)
  );

  always #(CLK_P / 2) clk = ~clk;

  int ntest = 0;
  int nfail = 0;
  int fetch_cnt = 0;
  logic [7:0] mem [int unsigned];

  logic        sh_en = 1'b1;
  logic        sh_mv [4] = '{default: 1'b0};
  logic [15:0] sh_md [4] = '{default: 16'h0};
  logic [1:0]  sh_dom [4] = '{default: 2'd0};
  logic [31:0] sh_base [4] = '{default: 32'h0};

  string       q_tag [$];
  logic [15:0] q_dev [$];
  logic [31:0] q_addr [$];
  logic [11:0] q_len [$];
  logic        q_wr [$];
  logic        q_allow [$];
  int          q_nf [$];

  task automatic check(string r, string what, logic [63:0] act, logic [63:0] exp);
    ntest++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_rd(logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 8'h00;
  endfunction

  function automatic logic excl(logic [31:0] base, logic [19:0] p);
    logic [7:0] b;
    b = mem_rd(base + 32'(p[19:3]));
    return b[p[2:0]];
  endfunction

  task automatic set_excl(logic [31:0] base, logic [19:0] p);
    logic [31:0] a;
    logic [7:0] b;
    a = base + 32'(p[19:3]);
    b = mem_rd(a);
    b[p[2:0]] = 1'b1;
    mem[a] = b;
  endtask

  task automatic model(input logic [15:0] d, input logic [31:0] a, input logic [11:0] l,
                       output logic allow, output int nf);
    int hit_i;
    logic [31:0] base;
    logic [31:0] e;
    hit_i = -1;
    allow = 1'b0;
    nf = 0;
    if (!sh_en) begin
      allow = 1'b1;
      return;
    end
    for (int i = 3; i >= 0; i--) if (sh_mv[i] && sh_md[i] == d) hit_i = i;
    if (hit_i < 0) return;
    base = sh_base[sh_dom[hit_i]];
    e = a + 32'(l);
    nf = 1;
    if (excl(base, a[31:12])) return;
    if (e[31:12] != a[31:12]) begin
      nf = 2;
      allow = !excl(base, e[31:12]);
    end else begin
      allow = 1'b1;
    end
  endtask

  task automatic cfg_wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = a;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (a[5:4])
      2'd0: sh_en = d[0];
      2'd1: if (a[3:0] < 4) begin
        sh_mv[a[1:0]] = d[31];
        sh_md[a[1:0]] = d[15:0];
        sh_dom[a[1:0]] = d[17:16];
      end
      2'd2: if (a[3:0] < 4) sh_base[a[1:0]] = d;
      default: ;
    endcase
  endtask

  task automatic send(string t, logic [15:0] d, logic [31:0] a, logic [11:0] l, logic w);
    logic al;
    int nf;
    model(d, a, l, al, nf);
    q_tag.push_back(t);
    q_dev.push_back(d);
    q_addr.push_back(a);
    q_len.push_back(l);
    q_wr.push_back(w);
    q_allow.push_back(al);
    q_nf.push_back(nf);
    @(negedge clk);
    req_dev = d;
    req_addr = a;
    req_len = l;
    req_write = w;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q_tag.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // bitmap memory responder with varying acceptance and latency
  logic        held = 1'b0;
  logic [31:0] held_addr = '0;
  initial begin
    int cyc;
    logic [31:0] a;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rd_req_valid) begin
        // R9: address held while the read is not taken
        if (held) check("R9", "read address held", rd_req_addr, held_addr);
        rd_req_ready = (cyc % 3 != 0);
        if (rd_req_ready) begin
          held = 1'b0;
          a = rd_req_addr;
          fetch_cnt++;
          @(negedge clk);
          rd_req_ready = 1'b0;
          repeat (cyc % 4) @(negedge clk);
          rd_rsp_data = mem_rd(a);
          rd_rsp_valid = 1'b1;
          @(negedge clk);
          rd_rsp_valid = 1'b0;
        end else begin
          held = 1'b1;
          held_addr = rd_req_addr;
        end
      end else begin
        rd_req_ready = 1'b0;
      end
    end
  end

  // scoreboard monitor
  initial begin
    int mcyc;
    string t;
    mcyc = 0;
    forever begin
      @(negedge clk);
      mcyc++;
      dec_ready = (mcyc % 4 != 2);
      if (dec_valid) check("R1", "no accept while deciding", req_ready, 1'b0);
      if (dec_valid && dec_ready) begin
        if (q_tag.size() == 0) begin
          check("R6", "unexpected decision", 1'b1, 1'b0);
        end else begin
          t = q_tag.pop_front();
          check(t, "allow", dec_allow, q_allow.pop_front());
          check(t, "read count", fetch_cnt, q_nf.pop_front());
          check("R6", "dev", dec_dev, q_dev.pop_front());
          check("R6", "addr", dec_addr, q_addr.pop_front());
          check("R6", "len", dec_len, q_len.pop_front());
          check("R6", "write", dec_write, q_wr.pop_front());
          fetch_cnt = 0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11", "req_ready", req_ready, 1'b1);
    check("R11", "dec_valid", dec_valid, 1'b0);
    check("R11", "rd_req_valid", rd_req_valid, 1'b0);
    check("R11", "stat_valid", stat_valid, 1'b0);
    send("R11", 16'h0100, 32'h0000_1234, 12'h010, 1'b0);
    drain();
    check("R8", "stat_valid set", stat_valid, 1'b1);
    check("R8", "stat_dev", stat_dev, 16'h0100);
    check("R8", "stat_addr", stat_addr, 32'h0000_1234);

    cfg_wr(6'h00, 32'h3);
    check("R8", "cleared", stat_valid, 1'b0);
    // R10 configuration
    cfg_wr(6'h10, 32'h8001_0100);
    cfg_wr(6'h11, 32'h8002_0200);
    cfg_wr(6'h12, 32'h8003_0100);
    cfg_wr(6'h21, 32'h1000_0000);
    cfg_wr(6'h22, 32'h2000_0000);
    cfg_wr(6'h23, 32'h3000_0000);
    cfg_wr(6'h2F, 32'hDEAD_0000);
    set_excl(32'h1000_0000, 20'h00005);
    set_excl(32'h1000_0000, 20'hFED00);
    set_excl(32'h1000_0000, 20'h12345);
    set_excl(32'h2000_0000, 20'h00004);

    send("R6", 16'h0100, 32'h0000_4000, 12'h0FF, 1'b1);
    send("R4", 16'h0100, 32'h0000_5010, 12'h00F, 1'b0);
    drain();
    check("R8", "first fault dev", stat_dev, 16'h0100);
    check("R8", "first fault addr", stat_addr, 32'h0000_5010);
    send("R4", 16'h0100, 32'h0000_6000, 12'h03F, 1'b1);
    send("R5", 16'h0100, 32'h0000_4F80, 12'h0FF, 1'b0);
    send("R5", 16'h0100, 32'h0000_5F80, 12'h0FF, 1'b1);
    send("R5", 16'h0100, 32'h0000_3F80, 12'h0FF, 1'b0);
    send("R5", 16'h0100, 32'h0000_7000, 12'hFFF, 1'b1);
    send("R2", 16'h0200, 32'h0000_5010, 12'h007, 1'b0);
    send("R2", 16'h0200, 32'h0000_4010, 12'h007, 1'b1);
    send("R3", 16'h0300, 32'h0000_4000, 12'h001, 1'b0);
    send("R10", 16'h0100, 32'hFED0_0008, 12'h003, 1'b1);
    send("R10", 16'h0100, 32'hFED0_1000, 12'h003, 1'b0);
    send("R4", 16'h0100, 32'h1234_5000, 12'h01F, 1'b0);
    drain();
    check("R8", "record kept dev", stat_dev, 16'h0100);
    check("R8", "record kept addr", stat_addr, 32'h0000_5010);

    cfg_wr(6'h10, 32'h0001_0100);
    send("R2", 16'h0100, 32'h0000_5010, 12'h00F, 1'b0);
    drain();

    cfg_wr(6'h00, 32'h0);
    send("R7", 16'h0300, 32'h0000_5010, 12'h0FF, 1'b1);
    send("R7", 16'h0200, 32'h0000_4010, 12'h0FF, 1'b0);
    drain();
    cfg_wr(6'h00, 32'h3);
    send("R3", 16'h0300, 32'h0000_8000, 12'h000, 1'b1);
    drain();
    check("R8", "new record dev", stat_dev, 16'h0300);
    check("R8", "new record addr", stat_addr, 32'h0000_8000);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule